// File: doc/BRIEF.md
# Program Address Generation Unit

This is a purely combinational unit that sits beside the fetch stage of an 8-bit accumulator microcontroller. The decode logic gives it an operation class, the address of the byte that follows the current instruction, the operand bytes, the accumulator, the 16-bit data pointer, the carry flag and the counter or compare operands. From these it produces the program counter for the next fetch, the code-memory address used for table lookups, the decremented loop counter, the updated carry and a flag that shows whether a conditional branch was taken.

All address arithmetic is modulo 2^16 and wraps without any indication. Absolute jumps stay inside the 2K page of the following instruction. Short and conditional branches add a signed byte offset to the following-instruction address. The compare-and-branch class also updates the carry as a side effect. The unit has no clock and no state. Fetch, decode, memories and the register file are outside it.

Top module: `pagu_top`

## Requirements
- R1: For class 1 (lookup via data pointer), `lookup_addr` equals `dptr` plus `acc` zero-extended, modulo 2^16, and `next_pc` equals `seq_pc`. For every class other than 1 and 2, `lookup_addr` is 0.
- R2: For class 2 (lookup via program counter), `lookup_addr` equals `seq_pc` plus `acc` zero-extended, modulo 2^16, and `next_pc` equals `seq_pc`.
- R3: For class 3 (absolute jump), `next_pc` is {`seq_pc`[15:11], `opcode`[7:5], `byte1`}. The opcode's low five bits are 00001.
- R4: For class 4 (long jump), `next_pc` is {`byte1`, `byte2`}, with `byte1` as the high byte.
- R5: For class 5 (short jump), `next_pc` is `seq_pc` plus `byte1` sign-extended, modulo 2^16.
- R6: For class 6 (branch on carry set) the branch is taken when `carry_in` is 1. For class 7 (branch on carry clear) it is taken when `carry_in` is 0. A taken branch gives `seq_pc` plus `byte1` sign-extended. A branch that is not taken gives `seq_pc`.
- R7: For class 8 (decrement and branch), `cnt_out` is `cnt_in` minus 1, so 0x00 becomes 0xFF. The branch to `seq_pc` plus `byte1` sign-extended is taken only when that new value is nonzero. For all other classes, `cnt_out` equals `cnt_in`.
- R8: For class 9 (compare and branch), the branch to `seq_pc` plus `byte2` sign-extended is taken when `cmp_a` differs from `cmp_b`. `carry_out` is 1 when `cmp_a` is less than `cmp_b` as unsigned values, and 0 otherwise. For all other classes, `carry_out` equals `carry_in`.
- R9: `taken` is 0 for every class except 6 to 9. For class 0 (sequential) and for the undefined classes 10 to 15, `next_pc` equals `seq_pc`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| seq_pc | input | 16 | Address of the byte after the current instruction |
| op_class | input | 4 | Decoded operation class (0 to 9 defined) |
| opcode | input | 8 | First instruction byte; bits 7:5 give the absolute page |
| byte1 | input | 8 | Second instruction byte |
| byte2 | input | 8 | Third instruction byte |
| acc | input | 8 | Accumulator |
| dptr | input | 16 | Data pointer |
| carry_in | input | 1 | Current carry flag |
| cnt_in | input | 8 | Loop counter register value |
| cmp_a | input | 8 | First compare operand |
| cmp_b | input | 8 | Second compare operand |
| next_pc | output | 16 | Program counter for the next fetch |
| lookup_addr | output | 16 | Code address for a table lookup |
| cnt_out | output | 8 | Counter value to write back |
| carry_out | output | 1 | Carry flag to write back |
| taken | output | 1 | Conditional branch was taken |

## Verification
The assertions assume the decoder gives an absolute-jump opcode whose low five bits are 00001 whenever class 3 is selected. They also assume the inputs settle together, because the checks are evaluated on combinational values. Every vector in the bench's table with class 3 uses one of the eight valid absolute opcodes. Opcodes for all other classes are free, so those vectors use arbitrary values. Each vector is applied as a whole between clock edges, and the outputs are sampled only after the inputs have been stable for a time step.

// File: rtl/pagu_pkg.sv
package pagu_pkg;
  typedef enum logic [3:0] {
    CLS_SEQ     = 4'd0,
    CLS_LOOK_DP = 4'd1,
    CLS_LOOK_PC = 4'd2,
    CLS_ABS     = 4'd3,
    CLS_LONG    = 4'd4,
    CLS_SHORT   = 4'd5,
    CLS_BR_C    = 4'd6,
    CLS_BR_NC   = 4'd7,
    CLS_DEC_BR  = 4'd8,
    CLS_CMP_BR  = 4'd9
  } op_class_e;
endpackage

// File: rtl/pagu_lookup.sv
module pagu_lookup #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  pagu_pkg::op_class_e cls,
  input  logic [ADDR_W-1:0]   seq_pc,
  input  logic [ADDR_W-1:0]   dptr,
  input  logic [DATA_W-1:0]   acc,
  output logic [ADDR_W-1:0]   lookup_addr
);
  import pagu_pkg::*;
  localparam int EXT_W = ADDR_W - DATA_W;

  logic              use_pc;
  logic              active;
  logic [ADDR_W-1:0] base;
  logic [ADDR_W-1:0] acc_ext;

  always_comb begin
    use_pc  = (cls == CLS_LOOK_PC);
    active  = use_pc || (cls == CLS_LOOK_DP);
    base    = use_pc ? seq_pc : dptr;
    acc_ext = {{EXT_W{1'b0}}, acc};
    lookup_addr = active ? (base + acc_ext) : '0;
  end

  always_comb begin
    if (cls == CLS_LOOK_DP)
      assert_dp_offset_R1: assert (lookup_addr - dptr == acc_ext);
    if (cls == CLS_LOOK_PC)
      assert_pc_offset_R2: assert (lookup_addr - seq_pc == acc_ext);
  end
endmodule

// File: rtl/pagu_cond.sv
module pagu_cond #(
  parameter int DATA_W = 8
) (
  input  pagu_pkg::op_class_e cls,
  input  logic                carry_in,
  input  logic [DATA_W-1:0]   cnt_in,
  input  logic [DATA_W-1:0]   cmp_a,
  input  logic [DATA_W-1:0]   cmp_b,
  output logic                taken,
  output logic [DATA_W-1:0]   cnt_out,
  output logic                carry_out
);
  import pagu_pkg::*;

  logic [DATA_W-1:0] cnt_dec;
  logic              cmp_lt;

  always_comb begin
    cnt_dec   = cnt_in - 1'b1;
    cmp_lt    = (cmp_a < cmp_b);
    taken     = 1'b0;
    cnt_out   = cnt_in;
    carry_out = carry_in;
    unique case (cls)
      CLS_BR_C:   taken = carry_in;
      CLS_BR_NC:  taken = !carry_in;
      CLS_DEC_BR: begin
        cnt_out = cnt_dec;
        taken   = (cnt_dec != '0);
      end
      CLS_CMP_BR: begin
        carry_out = cmp_lt;
        taken     = (cmp_a != cmp_b);
      end
      default: ;
    endcase
  end

  always_comb begin
    if (cls == CLS_BR_C || cls == CLS_BR_NC)
      assert_carry_branch_R6: assert (taken == (carry_in == (cls == CLS_BR_C)));
    if (cls == CLS_DEC_BR)
      assert_dec_branch_R7: assert (taken == (cnt_in != DATA_W'(1)));
    if (cls == CLS_CMP_BR)
      assert_less_means_differ_R8: assert (!carry_out || taken);
    if (cls == CLS_SEQ || cls == CLS_LONG || cls == CLS_SHORT || cls == CLS_ABS)
      assert_no_taken_R9: assert (!taken);
  end
endmodule

// File: rtl/pagu_target.sv
module pagu_target #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  pagu_pkg::op_class_e cls,
  input  logic [ADDR_W-1:0]   seq_pc,
  input  logic [DATA_W-1:0]   opcode,
  input  logic [DATA_W-1:0]   byte1,
  input  logic [DATA_W-1:0]   byte2,
  input  logic                taken,
  output logic [ADDR_W-1:0]   next_pc
);
  import pagu_pkg::*;
  localparam int PAGE_SEL_W = 3;
  localparam int PAGE_W     = DATA_W + PAGE_SEL_W;
  localparam int EXT_W      = ADDR_W - DATA_W;
  localparam logic [DATA_W-PAGE_SEL_W-1:0] ABS_LOW = 1;

  logic [DATA_W-1:0] rel_off;
  logic [ADDR_W-1:0] rel_target;
  logic [ADDR_W-1:0] abs_target;

  always_comb begin
    rel_off    = (cls == CLS_CMP_BR) ? byte2 : byte1;
    rel_target = seq_pc + {{EXT_W{rel_off[DATA_W-1]}}, rel_off};
    abs_target = {seq_pc[ADDR_W-1:PAGE_W], opcode[DATA_W-1:DATA_W-PAGE_SEL_W], byte1};
    unique case (cls)
      CLS_ABS:   next_pc = abs_target;
      CLS_LONG:  next_pc = {byte1, byte2};
      CLS_SHORT: next_pc = rel_target;
      CLS_BR_C, CLS_BR_NC, CLS_DEC_BR, CLS_CMP_BR:
                 next_pc = taken ? rel_target : seq_pc;
      default:   next_pc = seq_pc;
    endcase
  end

  always_comb begin
    if (cls == CLS_ABS) begin
      assert_abs_opcode_R3: assert (opcode[DATA_W-PAGE_SEL_W-1:0] == ABS_LOW);
      assert_abs_same_2k_R3: assert (next_pc[ADDR_W-1:PAGE_W] == seq_pc[ADDR_W-1:PAGE_W]);
    end
    if (cls == CLS_LONG)
      assert_long_halves_R4: assert (next_pc[DATA_W-1:0] == byte2 && next_pc[ADDR_W-1:DATA_W] == byte1);
    if ((cls == CLS_BR_C || cls == CLS_BR_NC || cls == CLS_DEC_BR || cls == CLS_CMP_BR) && !taken)
      assert_fallthrough_R6: assert (next_pc == seq_pc);
  end
endmodule

// File: rtl/pagu_top.sv
module pagu_top #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic [15:0] seq_pc,
  input  logic [3:0]  op_class,
  input  logic [7:0]  opcode,
  input  logic [7:0]  byte1,
  input  logic [7:0]  byte2,
  input  logic [7:0]  acc,
  input  logic [15:0] dptr,
  input  logic        carry_in,
  input  logic [7:0]  cnt_in,
  input  logic [7:0]  cmp_a,
  input  logic [7:0]  cmp_b,
  output logic [15:0] next_pc,
  output logic [15:0] lookup_addr,
  output logic [7:0]  cnt_out,
  output logic        carry_out,
  output logic        taken
);
  import pagu_pkg::*;

  op_class_e cls;
  assign cls = op_class_e'(op_class);

  pagu_lookup #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) lookup_i (
    .cls(cls), .seq_pc(seq_pc), .dptr(dptr), .acc(acc), .lookup_addr(lookup_addr)
  );

  pagu_cond #(.DATA_W(DATA_W)) cond_i (
    .cls(cls), .carry_in(carry_in), .cnt_in(cnt_in), .cmp_a(cmp_a), .cmp_b(cmp_b),
    .taken(taken), .cnt_out(cnt_out), .carry_out(carry_out)
  );

  pagu_target #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) target_i (
    .cls(cls), .seq_pc(seq_pc), .opcode(opcode), .byte1(byte1), .byte2(byte2),
    .taken(taken), .next_pc(next_pc)
  );

  always_comb begin
    if (op_class > 4'd9)
      assert_undefined_seq_R9: assert (next_pc == seq_pc && !taken);
  end
endmodule

// File: tb/pagu_top_tb_top.sv
module pagu_top_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NVEC = 19;

  typedef struct packed {
    logic [3:0]  cls;
    logic [15:0] seq;
    logic [7:0]  opc;
    logic [7:0]  b1;
    logic [7:0]  b2;
    logic [7:0]  acc;
    logic [15:0] dp;
    logic        cin;
    logic [7:0]  cnt;
    logic [7:0]  ca;
    logic [7:0]  cb;
    logic [15:0] exp_pc;
    logic        exp_tk;
  } vec_t;

  localparam vec_t VECS [0:NVEC-1] = '{
    '{4'd0, 16'h1234, 8'h00, 8'h11, 8'h22, 8'h33, 16'h4444, 1'b0, 8'h05, 8'h01, 8'h02, 16'h1234, 1'b0},
    '{4'd1, 16'h0100, 8'h00, 8'h00, 8'h00, 8'hF0, 16'h12FF, 1'b0, 8'h00, 8'h00, 8'h00, 16'h0100, 1'b0},
    '{4'd2, 16'hFFF0, 8'h00, 8'h00, 8'h00, 8'h20, 16'h0000, 1'b1, 8'h00, 8'h00, 8'h00, 16'hFFF0, 1'b0},
    '{4'd3, 16'h0800, 8'hE1, 8'h34, 8'h00, 8'h00, 16'h0000, 1'b0, 8'h00, 8'h00, 8'h00, 16'h0F34, 1'b0},
    '{4'd3, 16'hABCD, 8'h01, 8'h00, 8'h00, 8'h00, 16'h0000, 1'b0, 8'h00, 8'h00, 8'h00, 16'hA800, 1'b0},
    '{4'd4, 16'h0003, 8'h02, 8'hBE, 8'hEF, 8'h00, 16'h0000, 1'b0, 8'h00, 8'h00, 8'h00, 16'hBEEF, 1'b0},
    '{4'd5, 16'h1000, 8'h80, 8'h80, 8'h00, 8'h00, 16'h0000, 1'b0, 8'h00, 8'h00, 8'h00, 16'h0F80, 1'b0},
    '{4'd5, 16'hFFF0, 8'h80, 8'h7F, 8'h00, 8'h00, 16'h0000, 1'b0, 8'h00, 8'h00, 8'h00, 16'h006F, 1'b0},
    '{4'd5, 16'h0005, 8'h80, 8'hF0, 8'h00, 8'h00, 16'h0000, 1'b0, 8'h00, 8'h00, 8'h00, 16'hFFF5, 1'b0},
    '{4'd6, 16'h2000, 8'h40, 8'h10, 8'h00, 8'h00, 16'h0000, 1'b1, 8'h00, 8'h00, 8'h00, 16'h2010, 1'b1},
    '{4'd6, 16'h2000, 8'h40, 8'h10, 8'h00, 8'h00, 16'h0000, 1'b0, 8'h00, 8'h00, 8'h00, 16'h2000, 1'b0},
    '{4'd7, 16'h2000, 8'h50, 8'hFE, 8'h00, 8'h00, 16'h0000, 1'b0, 8'h00, 8'h00, 8'h00, 16'h1FFE, 1'b1},
    '{4'd7, 16'h2000, 8'h50, 8'hFE, 8'h00, 8'h00, 16'h0000, 1'b1, 8'h00, 8'h00, 8'h00, 16'h2000, 1'b0},
    '{4'd8, 16'h3000, 8'hD8, 8'h05, 8'h00, 8'h00, 16'h0000, 1'b0, 8'h00, 8'h00, 8'h00, 16'h3005, 1'b1},
    '{4'd8, 16'h3000, 8'hD8, 8'h05, 8'h00, 8'h00, 16'h0000, 1'b0, 8'h01, 8'h00, 8'h00, 16'h3000, 1'b0},
    '{4'd9, 16'h4000, 8'hB4, 8'h55, 8'h08, 8'h00, 16'h0000, 1'b0, 8'h00, 8'h10, 8'h20, 16'h4008, 1'b1},
    '{4'd9, 16'h4000, 8'hB4, 8'h55, 8'h08, 8'h00, 16'h0000, 1'b1, 8'h00, 8'h20, 8'h20, 16'h4000, 1'b0},
    '{4'd9, 16'h4000, 8'hB4, 8'h55, 8'h08, 8'h00, 16'h0000, 1'b1, 8'h00, 8'hFF, 8'h00, 16'h4008, 1'b1},
    '{4'd15, 16'h5555, 8'h00, 8'h12, 8'h34, 8'h56, 16'h7777, 1'b1, 8'h09, 8'h01, 8'h02, 16'h5555, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] seq_pc = '0, dptr = '0;
  logic [3:0]  op_class = '0;
  logic [7:0]  opcode = '0, byte1 = '0, byte2 = '0, acc = '0, cnt_in = '0, cmp_a = '0, cmp_b = '0;
  logic        carry_in = 1'b0;
  logic [15:0] next_pc, lookup_addr;
  logic [7:0]  cnt_out;
  logic        carry_out, taken;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pagu_top dut_i (
    .seq_pc(seq_pc), .op_class(op_class), .opcode(opcode), .byte1(byte1), .byte2(byte2),
    .acc(acc), .dptr(dptr), .carry_in(carry_in), .cnt_in(cnt_in), .cmp_a(cmp_a), .cmp_b(cmp_b),
    .next_pc(next_pc), .lookup_addr(lookup_addr), .cnt_out(cnt_out),
    .carry_out(carry_out), .taken(taken)
  );

  task automatic check(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    @(negedge clk);
    op_class = v.cls; seq_pc = v.seq; opcode = v.opc; byte1 = v.b1; byte2 = v.b2;
    acc = v.acc; dptr = v.dp; carry_in = v.cin; cnt_in = v.cnt; cmp_a = v.ca; cmp_b = v.cb;
    #1;
  endtask

  function automatic string req_of(input logic [3:0] c);
    case (c)
      4'd1: return "R1";
      4'd2: return "R2";
      4'd3: return "R3";
      4'd4: return "R4";
      4'd5: return "R5";
      4'd6, 4'd7: return "R6";
      4'd8: return "R7";
      4'd9: return "R8";
      default: return "R9";
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    #1;
    check("R9", "reset next_pc", next_pc, 16'h0000);
    check("R9", "reset taken", {15'd0, taken}, 16'd0);
    check("R1", "reset lookup", lookup_addr, 16'h0000);
    rst_n = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      vec_t v;
      logic [15:0] exp_lk;
      logic [7:0]  exp_cnt;
      logic        exp_c;
      v = VECS[i];
      apply(v);
      exp_lk  = (v.cls == 4'd1) ? v.dp + {8'd0, v.acc} :
                (v.cls == 4'd2) ? v.seq + {8'd0, v.acc} : 16'h0000;
      exp_cnt = (v.cls == 4'd8) ? v.cnt - 8'd1 : v.cnt;
      exp_c   = (v.cls == 4'd9) ? (v.ca < v.cb) : v.cin;
      check(req_of(v.cls), "next_pc", next_pc, v.exp_pc);
      check(req_of(v.cls), "taken", {15'd0, taken}, {15'd0, v.exp_tk});
      check((v.cls == 4'd1 || v.cls == 4'd2) ? req_of(v.cls) : "R1", "lookup_addr", lookup_addr, exp_lk);
      check("R7", "cnt_out", {8'd0, cnt_out}, {8'd0, exp_cnt});
      check("R8", "carry_out", {15'd0, carry_out}, {15'd0, exp_c});
    end

    // R1: dptr wrap at 64K with full carry into high byte
    apply('{4'd1, 16'h0000, 8'h00, 8'h00, 8'h00, 8'hFF, 16'hFFFF, 1'b0, 8'h00, 8'h00, 8'h00, 16'h0000, 1'b0});
    check("R1", "dptr wrap", lookup_addr, 16'h00FE);
    // R3: all eight pages spliced into the same 2K region
    for (int p = 0; p < 8; p++) begin
      apply('{4'd3, 16'h77FF, {p[2:0], 5'b00001}, 8'hA5, 8'h00, 8'h00, 16'h0000, 1'b0, 8'h00, 8'h00, 8'h00, 16'h0000, 1'b0});
      check("R3", "page splice", next_pc, {5'b01110, p[2:0], 8'hA5});
    end
    // R7: counter 0xFF decrements to 0xFE and branches
    apply('{4'd8, 16'hFFFF, 8'h00, 8'h01, 8'h00, 8'h00, 16'h0000, 1'b0, 8'hFF, 8'h00, 8'h00, 16'h0000, 1'b0});
    check("R7", "dec wrap pc", next_pc, 16'h0000);
    check("R7", "dec cnt", {8'd0, cnt_out}, 16'h00FE);
    // R8: compare offset from byte2 not byte1, backward
    apply('{4'd9, 16'h0010, 8'h00, 8'h05, 8'hF0, 8'h00, 16'h0000, 1'b0, 8'h00, 8'h7F, 8'h80, 16'h0000, 1'b0});
    check("R8", "cmp backward", next_pc, 16'h0000);
    check("R8", "cmp carry", {15'd0, carry_out}, 16'd1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule